// File: doc/BRIEF.md
# UART Interrupt Control and Status Unit

This unit collects the interrupt conditions of a UART into a four-bit cause register and drives the single interrupt line that software services. Four conditions are recorded. A receive condition holds while the receive FIFO fill level is non-zero and at or above a programmable receive threshold. A transmit condition holds while the transmit FIFO fill level is at or below a programmable transmit threshold. A modem-status event occurs on each edge of the clear-to-send input after a two-flop synchroniser. A receive-timeout event occurs when the receive FIFO has held data for a fixed number of oversample ticks with no new character arriving.

An eight-bit control register holds the global UART enable, per-cause enable bits and three mode bits that are only stored. The interrupt line is the OR of the recorded causes, each masked by its enable bit, and is forced low while the global enable is clear. Software services an interrupt by reading the cause register, handling the sources and writing the clear strobe. A level condition that still holds comes back one clock later, so software can loop until the register reads zero. A flag word reports the synchronised clear-to-send state, transmitter busy and the FIFO empty and full states. The FIFOs and the serial engines are outside this block and appear only as level and event inputs.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A write on `ctrl_we` loads `ctrl_wdata` into `ctrl_q` at the next clock edge. The bit positions are: 0 global enable, 1 infrared mode, 2 infrared low power, 3 modem-status enable, 4 receive enable, 5 transmit enable, 6 receive-timeout enable, 7 loopback. Bits 1, 2 and 7 are only stored.
- R2: Cause bit 1 is set at a clock edge where `rx_level` is non-zero and `rx_level` >= the receive threshold. The receive threshold is loaded from `thr_wdata` on `rx_thr_we`.
- R3: Cause bit 2 is set at a clock edge where `tx_level` <= the transmit threshold. The transmit threshold is loaded from `thr_wdata` on `tx_thr_we`.
- R4: `cts_in` passes through two flops. Cause bit 0 is set on either edge of the synchronised value, which is the third clock edge after `cts_in` changes.
- R5: A tick counter restarts at zero while `rx_level` is zero or `rx_char` is high, and otherwise counts `os_tick` pulses up to TOUT_TICKS and holds there. Cause bit 3 is set at the edge of the TOUT_TICKS-th counted tick.
- R6: A set cause bit stays set until `cause_clr` is high at a clock edge. That edge clears all four bits, even for conditions present at the same edge. A condition that still holds sets its bit again at the following edge.
- R7: While `ctrl_q[0]` is 1, `irq` equals the OR over i of `cause_q[i]` AND `ctrl_q[3+i]`, with no register delay.
- R8: While `ctrl_q[0]` is 0, `irq` is 0 whatever the causes and enables. Causes are still recorded while the block is disabled.
- R9: `flags_q` has bit 0 set to the synchronised clear-to-send, bits 1 and 2 set to 0, bit 3 set to `tx_busy`, bit 4 set when the receive FIFO is empty, bit 5 set when the transmit FIFO is full, bit 6 set when the receive FIFO is full and bit 7 set when the transmit FIFO is empty. Full means a level equal to FIFO_DEPTH.
- R10: During reset, `ctrl_q`, `cause_q` and `irq` are 0, the receive threshold is 1 and the transmit threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| rx_thr_we | input | 1 | Receive threshold write strobe |
| tx_thr_we | input | 1 | Transmit threshold write strobe |
| thr_wdata | input | LVL_W | Threshold write data |
| cause_clr | input | 1 | Cause register clear strobe (a write to it) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_char | input | 1 | Pulse: a character entered the receive FIFO |
| os_tick | input | 1 | Oversample tick pulse |
| tx_busy | input | 1 | Transmitter busy |
| cts_in | input | 1 | Asynchronous clear-to-send input |
| ctrl_q | output | 8 | Control register |
| rx_thr_q | output | LVL_W | Receive threshold |
| tx_thr_q | output | LVL_W | Transmit threshold |
| cause_q | output | 4 | Cause register |
| flags_q | output | 8 | Flag word |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets a clear strobe that arrives while a level condition holds. A design that lets the set win would never show the zero cycle, and a design that drops the condition would lose the interrupt. It counts the clear-to-send path edge by edge, so a synchroniser with one flop too many or too few moves the modem cause by a cycle. It drives the timeout across exactly 31 and 32 ticks and with characters arriving mid-count. A counter that fails to restart, or that fires again while saturated, shows up as an early or repeated cause. It also toggles the global enable with causes pending, and a leaking enable gate raises `irq` while disabled.

// File: rtl/uic_pkg.sv
package uic_pkg;
  localparam int CTRL_W     = 8;
  localparam int CAUSE_W    = 4;
  localparam int C_EN       = 0;
  localparam int C_EN_BASE  = 3;
  localparam int K_MDM      = 0;
  localparam int K_RX       = 1;
  localparam int K_TX       = 2;
  localparam int K_TOUT     = 3;

  function automatic logic rx_hit(input int unsigned lvl, input int unsigned thr);
    return (lvl != 0) && (lvl >= thr);
  endfunction

  function automatic logic tx_hit(input int unsigned lvl, input int unsigned thr);
    return lvl <= thr;
  endfunction

  function automatic logic irq_of(input logic [CAUSE_W-1:0] cause,
                                  input logic [CTRL_W-1:0] ctrl);
    return ctrl[C_EN] & (|(cause & ctrl[C_EN_BASE +: CAUSE_W]));
  endfunction

  function automatic logic [7:0] flag_word(input logic cts, input logic busy,
                                           input logic rxe, input logic txf,
                                           input logic rxf, input logic txe);
    return {txe, rxf, txf, rxe, busy, 2'b00, cts};
  endfunction
endpackage

// File: rtl/uic_cts_sync.sv
module uic_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_in,
  output logic cts_s,
  output logic cts_edge
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], cts_in};
  end

  assign cts_s    = sh[STAGES-1];
  assign cts_edge = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/uic_rx_timeout.sv
module uic_rx_timeout #(
  parameter int TOUT_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_empty,
  input  logic rx_char,
  input  logic os_tick,
  output logic tout_evt
);
  localparam int CW = $clog2(TOUT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TOUT_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(TOUT_TICKS);

  logic [CW-1:0] cnt;
  logic          restart;

  assign restart  = rx_empty | rx_char;
  assign tout_evt = !restart && os_tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (restart)                cnt <= '0;
    else if (os_tick && cnt != FULL) cnt <= cnt + 1'b1;
  end

  // R5
  tout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout_evt |-> (!rx_empty && !rx_char && os_tick));

  // R5
  tout_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tout_evt |=> !tout_evt);
endmodule

// File: rtl/uic_cause_reg.sv
module uic_cause_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  output logic [N-1:0] cause_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          cause_q[i] <= 1'b0;
      else if (clr)        cause_q[i] <= 1'b0;
      else if (set_vec[i]) cause_q[i] <= 1'b1;
    end
  end

  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cause_q == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uic_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int TOUT_TICKS = 32,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_we,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  input  logic                rx_thr_we,
  input  logic                tx_thr_we,
  input  logic [LVL_W-1:0]    thr_wdata,
  input  logic                cause_clr,
  input  logic [LVL_W-1:0]    rx_level,
  input  logic [LVL_W-1:0]    tx_level,
  input  logic                rx_char,
  input  logic                os_tick,
  input  logic                tx_busy,
  input  logic                cts_in,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [LVL_W-1:0]    rx_thr_q,
  output logic [LVL_W-1:0]    tx_thr_q,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [7:0]          flags_q,
  output logic                irq
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);

  logic               cts_s, cts_edge, tout_evt;
  logic               rx_empty, rx_full, tx_empty, tx_full;
  logic [CAUSE_W-1:0] set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      rx_thr_q <= LVL_W'(1);
      tx_thr_q <= '0;
    end else begin
      if (ctrl_we)   ctrl_q   <= ctrl_wdata;
      if (rx_thr_we) rx_thr_q <= thr_wdata;
      if (tx_thr_we) tx_thr_q <= thr_wdata;
    end
  end

  assign rx_empty = (rx_level == '0);
  assign tx_empty = (tx_level == '0);
  assign rx_full  = (rx_level == FULL_LVL);
  assign tx_full  = (tx_level == FULL_LVL);

  uic_cts_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cts_in(cts_in),
    .cts_s(cts_s), .cts_edge(cts_edge)
  );

  uic_rx_timeout #(.TOUT_TICKS(TOUT_TICKS)) u_tout (
    .clk(clk), .rst_n(rst_n), .rx_empty(rx_empty), .rx_char(rx_char),
    .os_tick(os_tick), .tout_evt(tout_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[K_MDM]  = cts_edge;
    set_vec[K_RX]   = rx_hit(32'(rx_level), 32'(rx_thr_q));
    set_vec[K_TX]   = tx_hit(32'(tx_level), 32'(tx_thr_q));
    set_vec[K_TOUT] = tout_evt;
  end

  uic_cause_reg #(.N(CAUSE_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr(cause_clr),
    .cause_q(cause_q)
  );

  assign irq     = irq_of(cause_q, ctrl_q);
  assign flags_q = flag_word(cts_s, tx_busy, rx_empty, tx_full, rx_full, tx_empty);

  // R4
  mdm_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_edge && !cause_clr) |=> cause_q[K_MDM]);

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[C_EN]);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cause_q != '0));

  // R2
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != '0 && rx_level >= rx_thr_q && !cause_clr) |=> cause_q[K_RX]);
endmodule

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
  localparam int DEPTH = 16;
  localparam int LW    = 5;
  localparam int TOUT  = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ctrl_we = 0, rx_thr_we = 0, tx_thr_we = 0, cause_clr = 0;
  logic [7:0]    ctrl_wdata = '0;
  logic [LW-1:0] thr_wdata = '0, rx_level = '0, tx_level = 5'd8;
  logic          rx_char = 0, os_tick = 0, tx_busy = 0, cts_in = 0;
  logic [7:0]    ctrl_q, flags_q;
  logic [LW-1:0] rx_thr_q, tx_thr_q;
  logic [3:0]    cause_q;
  logic          irq;

  uart_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .rx_thr_we(rx_thr_we), .tx_thr_we(tx_thr_we), .thr_wdata(thr_wdata),
    .cause_clr(cause_clr), .rx_level(rx_level), .tx_level(tx_level),
    .rx_char(rx_char), .os_tick(os_tick), .tx_busy(tx_busy), .cts_in(cts_in),
    .ctrl_q(ctrl_q), .rx_thr_q(rx_thr_q), .tx_thr_q(tx_thr_q),
    .cause_q(cause_q), .flags_q(flags_q), .irq(irq)
  );

  int checks = 0, fails = 0, cyc_n = 0;

  // behavioural reference model
  logic [7:0] m_ctrl;
  int         m_rxthr, m_txthr, m_cnt;
  logic [3:0] m_cause;
  logic       m_s1, m_s2, m_s3;

  always @(posedge clk) begin
    logic [3:0] setv;
    if (!rst_n) begin
      m_ctrl = 0; m_rxthr = 1; m_txthr = 0; m_cnt = 0; m_cause = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      setv[0] = (m_s2 != m_s3);
      setv[1] = (rx_level != 0) && (int'(rx_level) >= m_rxthr);
      setv[2] = (int'(tx_level) <= m_txthr);
      setv[3] = 1'b0;
      if (rx_level == 0 || rx_char) m_cnt = 0;
      else if (os_tick && m_cnt < TOUT) begin
        setv[3] = (m_cnt == TOUT - 1);
        m_cnt++;
      end
      m_cause = cause_clr ? 4'b0 : (m_cause | setv);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cts_in;
      if (ctrl_we)   m_ctrl  = ctrl_wdata;
      if (rx_thr_we) m_rxthr = int'(thr_wdata);
      if (tx_thr_we) m_txthr = int'(thr_wdata);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    logic       e_irq;
    logic [7:0] e_flags;
    string      ctag[4] = '{"R4 modem cause", "R2 rx cause", "R3 tx cause", "R5 timeout cause"};
    e_irq   = m_ctrl[0] && |(m_cause & m_ctrl[6:3]);
    e_flags = {tx_level == 0, rx_level == DEPTH, tx_level == DEPTH, rx_level == 0,
               tx_busy, 2'b00, m_s2};
    for (int i = 0; i < 4; i++) chk(cause_q[i] === m_cause[i], ctag[i], cause_q[i], m_cause[i]);
    chk(irq === e_irq, m_ctrl[0] ? "R7 irq" : "R8 irq disabled", irq, e_irq);
    chk(ctrl_q === m_ctrl, "R1 ctrl", ctrl_q, m_ctrl);
    chk(flags_q === e_flags, "R9 flags", flags_q, e_flags);
    chk(int'(rx_thr_q) == m_rxthr, "R2 rx threshold", rx_thr_q, m_rxthr);
    chk(int'(tx_thr_q) == m_txthr, "R3 tx threshold", tx_thr_q, m_txthr);
  endtask

  task automatic cyc(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rst_n) compare_all();
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 60000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_n, 60000);
      summary();
      $finish;
    end
  end

  initial begin
    // R10 reset state
    cyc(3);
    chk(cause_q == 0, "R10 reset cause", cause_q, 0);
    chk(irq == 0, "R10 reset irq", irq, 0);
    chk(ctrl_q == 0, "R10 reset ctrl", ctrl_q, 0);
    chk(rx_thr_q == 1, "R10 reset rx threshold", rx_thr_q, 1);
    chk(tx_thr_q == 0, "R10 reset tx threshold", tx_thr_q, 0);
    rst_n = 1'b1;
    cyc(2);

    // R1 control write
    ctrl_we = 1; ctrl_wdata = 8'hA5; cyc();
    ctrl_we = 0;
    chk(ctrl_q == 8'hA5, "R1 ctrl write", ctrl_q, 8'hA5);

    // R2 receive threshold
    rx_thr_we = 1; thr_wdata = 5'd4; rx_level = 5'd3; cause_clr = 1; cyc();
    rx_thr_we = 0; cause_clr = 0; cyc();
    chk(cause_q[1] == 0, "R2 below threshold", cause_q[1], 0);
    rx_level = 5'd4; cyc();
    chk(cause_q[1] == 1, "R2 at threshold", cause_q[1], 1);

    // R3 transmit threshold
    tx_thr_we = 1; thr_wdata = 5'd2; tx_level = 5'd3; cause_clr = 1; cyc();
    tx_thr_we = 0; cause_clr = 0; cyc();
    chk(cause_q[2] == 0, "R3 above threshold", cause_q[2], 0);
    tx_level = 5'd2; cyc();
    chk(cause_q[2] == 1, "R3 at threshold", cause_q[2], 1);

    // R6 clear wins, then a holding condition returns
    cause_clr = 1; cyc();
    chk(cause_q[2] == 0, "R6 cleared", cause_q[2], 0);
    cause_clr = 0; cyc();
    chk(cause_q[2] == 1, "R6 set again", cause_q[2], 1);

    // R4 modem edge latency, rising then falling
    for (int e = 0; e < 2; e++) begin
      cyc(4);
      cause_clr = 1; cyc();
      cause_clr = 0; cts_in = ~cts_in; cyc(2);
      chk(cause_q[0] == 0, "R4 before sync", cause_q[0], 0);
      cyc();
      chk(cause_q[0] == 1, "R4 after sync", cause_q[0], 1);
    end

    // R5 timeout after exactly TOUT ticks
    cause_clr = 1; rx_char = 1; rx_level = 5'd1; os_tick = 1; cyc();
    cause_clr = 0; rx_char = 0;
    cyc(TOUT - 1);
    chk(cause_q[3] == 0, "R5 one tick short", cause_q[3], 0);
    cyc();
    chk(cause_q[3] == 1, "R5 timeout", cause_q[3], 1);
    cause_clr = 1; cyc(); cause_clr = 0;
    cyc(20); rx_char = 1; cyc(); rx_char = 0; cyc(20);
    chk(cause_q[3] == 0, "R5 restart on char", cause_q[3], 0);
    os_tick = 0;

    // R7 / R8 global enable gating
    ctrl_we = 1; ctrl_wdata = 8'h79; cyc(); ctrl_we = 0;
    chk(irq == 1, "R7 enabled irq", irq, 1);
    ctrl_we = 1; ctrl_wdata = 8'h78; cyc(); ctrl_we = 0;
    chk(irq == 0, "R8 disabled irq", irq, 0);

    // randomised traffic against the model
    for (int i = 0; i < 6000; i++) begin
      ctrl_we    = ($urandom_range(15, 0) == 0);
      ctrl_wdata = 8'($urandom);
      rx_thr_we  = ($urandom_range(40, 0) == 0);
      tx_thr_we  = ($urandom_range(40, 0) == 0);
      thr_wdata  = 5'($urandom_range(DEPTH, 0));
      cause_clr  = ($urandom_range(7, 0) == 0);
      if ($urandom_range(29, 0) == 0) rx_level = 5'($urandom_range(DEPTH, 0));
      if ($urandom_range(29, 0) == 0) tx_level = 5'($urandom_range(DEPTH, 0));
      rx_char    = ($urandom_range(99, 0) == 0);
      os_tick    = ($urandom_range(1, 0) == 0);
      tx_busy    = 1'($urandom);
      if ($urandom_range(9, 0) == 0) cts_in = ~cts_in;
      cyc();
    end

    summary();
    $finish;
  end
endmodule